// File: doc/BRIEF.md
# Flash Protected-Range Access Checker

This block stands in front of a serial-flash cycle engine and decides, one request at a time, whether a flash cycle may start. Five range registers each describe a window of the 32 MB flash address space at 4 KB page granularity, with separate enables that guard against reads and against writes or erases. Each incoming cycle address is compared with every enabled window. A hit on a window whose enable matches the cycle kind denies the cycle.

The ranges can be programmed freely while the block is open. During that time every request is granted. A lockdown input freezes the register bank and turns the protection on, and only reset returns the block to the open state. The response arrives one clock after the request as either grant or deny. Every denial also sets a sticky violation flag, which stays set until a clear pulse is applied.

Top module: `flash_range_guard`

## Requirements
- R1: There are five range registers selected by `cfg_idx` values 0 to 4. A write with `cfg_idx` 5, 6 or 7 changes no register.
- R2: Register word layout: bit 31 is the write/erase protect enable, bit 15 is the read protect enable, bits 28:16 are the upper page and bits 12:0 are the lower page. A page is flash address bits 24:12. Bits 30:29 and 14:13 have no effect.
- R3: An address falls in a range when lower page ≤ address page ≤ upper page, both limits inclusive. Byte offsets 0x000 through 0xFFF of a boundary page are therefore covered. A range whose lower page exceeds its upper page covers nothing.
- R4: `req_kind`=1 (write or erase) is denied only by ranges with bit 31 set. `req_kind`=0 (read) is denied only by ranges with bit 15 set.
- R5: Before lockdown, every request is granted whatever the ranges hold.
- R6: A `lock_in` pulse sets lockdown, and lockdown stays set until reset. After lockdown, register writes are ignored. A register write in the same cycle as the lockdown pulse still takes effect.
- R7: A request sampled at a clock edge produces `rsp_valid` on that edge, with exactly one of `rsp_grant` and `rsp_deny` set. Without a request, all three outputs are 0.
- R8: A request is denied if any one of the enabled, matching ranges covers it. Overlapping ranges are allowed.
- R9: Each denial sets `viol_flag`. A `viol_clr` pulse clears it. When a clear and a new denial fall in the same cycle, the flag ends up set.
- R10: After reset, the block is open, all ranges are disabled, and `rsp_valid`, `rsp_grant`, `rsp_deny` and `viol_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Range register write strobe |
| cfg_idx | input | 3 | Range register index |
| cfg_wdata | input | 32 | Range register write data |
| lock_in | input | 1 | Lockdown request pulse |
| req_valid | input | 1 | Flash cycle request |
| req_addr | input | 25 | Flash cycle byte address |
| req_kind | input | 1 | 1 = write or erase, 0 = read |
| viol_clr | input | 1 | Write-1 clear of the violation flag |
| rsp_valid | output | 1 | Response present |
| rsp_grant | output | 1 | Cycle may start |
| rsp_deny | output | 1 | Cycle blocked |
| viol_flag | output | 1 | Sticky violation flag |

## Verification
Two pairs of events can fall in the same cycle. The first is a flag clear together with a new denial. The bench asserts `viol_clr` in the same cycle as a request that must be denied, and expects the flag to read 1 afterwards. It then repeats the clear with a granted request and expects 0. The second is a lockdown pulse together with a register write. The bench applies both in one cycle, and the sweep that follows must reflect the new register contents with protection active.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;

  localparam int FLASH_AW   = 25;
  localparam int PAGE_SHIFT = 12;
  localparam int PAGE_W     = FLASH_AW - PAGE_SHIFT;
  localparam int CFG_W      = 32;

  // field positions inside a range word
  localparam int WP_BIT   = 31;
  localparam int RP_BIT   = 15;
  localparam int UP_LSB   = 16;
  localparam int LO_LSB   = 0;

  typedef struct packed {
    logic              wp;
    logic              rp;
    logic [PAGE_W-1:0] upper;
    logic [PAGE_W-1:0] lower;
  } range_cfg_t;

  function automatic range_cfg_t unpack_range(input logic [CFG_W-1:0] w);
    range_cfg_t r;
    r.wp    = w[WP_BIT];
    r.rp    = w[RP_BIT];
    r.upper = w[UP_LSB +: PAGE_W];
    r.lower = w[LO_LSB +: PAGE_W];
    return r;
  endfunction

endpackage

// File: rtl/flash_guard_regs.sv
module flash_guard_regs
  import flash_guard_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  parameter int IDX_W      = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [IDX_W-1:0]             wr_idx,
  input  logic [CFG_W-1:0]             wr_data,
  input  logic                         lock_req,
  output logic                         locked,
  output range_cfg_t [NUM_RANGES-1:0]  cfg
);

  logic       lock_q, lock_d;
  logic       wr_ok;
  range_cfg_t new_cfg;

  // the write is judged against the lock state before this edge
  assign wr_ok   = wr_en & ~lock_q & (int'(wr_idx) < NUM_RANGES);
  assign new_cfg = unpack_range(wr_data);
  assign lock_d  = lock_q | lock_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lock_q <= 1'b0;
    else        lock_q <= lock_d;
  end

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_entry
    logic       sel;
    range_cfg_t entry_q, entry_d;

    assign sel = wr_ok & (int'(wr_idx) == g);

    always_comb begin
      entry_d = entry_q;
      if (sel) entry_d = new_cfg;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   entry_q <= '0;
      else if (sel) entry_q <= entry_d;
    end

    assign cfg[g] = entry_q;
  end

  assign locked = lock_q;

endmodule

// File: rtl/flash_guard_match.sv
module flash_guard_match
  import flash_guard_pkg::*;
#(
  parameter int NUM_RANGES = 5
) (
  input  range_cfg_t [NUM_RANGES-1:0] cfg,
  input  logic [FLASH_AW-1:0]         addr,
  input  logic                        is_write,
  output logic [NUM_RANGES-1:0]       viol
);

  logic [PAGE_W-1:0] page;
  assign page = addr[FLASH_AW-1:PAGE_SHIFT];

  for (genvar g = 0; g < NUM_RANGES; g++) begin : g_cmp
    logic above_lo, below_up, guarded;
    assign above_lo = page >= cfg[g].lower;
    assign below_up = page <= cfg[g].upper;
    assign guarded  = is_write ? cfg[g].wp : cfg[g].rp;
    assign viol[g]  = above_lo & below_up & guarded;
  end

endmodule

// File: rtl/flash_guard_resp.sv
module flash_guard_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic any_viol,
  input  logic locked,
  input  logic flag_clr,
  output logic rsp_valid,
  output logic rsp_grant,
  output logic rsp_deny,
  output logic flag
);

  logic deny_now;
  logic valid_d, grant_d, deny_d, flag_d;
  logic valid_q, grant_q, deny_q, flag_q;

  assign deny_now = req_valid & locked & any_viol;

  always_comb begin
    valid_d = req_valid;
    grant_d = req_valid & ~deny_now;
    deny_d  = deny_now;
    flag_d  = flag_q;
    if (flag_clr) flag_d = 1'b0;
    if (deny_now) flag_d = 1'b1;   // a new denial wins over a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      grant_q <= grant_d;
      deny_q  <= deny_d;
      flag_q  <= flag_d;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_grant = grant_q;
  assign rsp_deny  = deny_q;
  assign flag      = flag_q;

endmodule

// File: rtl/flash_range_guard.sv
module flash_range_guard
  import flash_guard_pkg::*;
#(
  parameter int NUM_RANGES = 5,
  localparam int IDX_W     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [IDX_W-1:0]    cfg_idx,
  input  logic [CFG_W-1:0]    cfg_wdata,
  input  logic                lock_in,
  input  logic                req_valid,
  input  logic [FLASH_AW-1:0] req_addr,
  input  logic                req_kind,
  input  logic                viol_clr,
  output logic                rsp_valid,
  output logic                rsp_grant,
  output logic                rsp_deny,
  output logic                viol_flag
);

  logic                        lock_q;
  range_cfg_t [NUM_RANGES-1:0] cfg_q;
  logic [NUM_RANGES-1:0]       viol_vec;

  flash_guard_regs #(.NUM_RANGES(NUM_RANGES), .IDX_W(IDX_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_idx),
    .wr_data  (cfg_wdata),
    .lock_req (lock_in),
    .locked   (lock_q),
    .cfg      (cfg_q)
  );

  flash_guard_match #(.NUM_RANGES(NUM_RANGES)) u_match (
    .cfg      (cfg_q),
    .addr     (req_addr),
    .is_write (req_kind),
    .viol     (viol_vec)
  );

  flash_guard_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .any_viol  (|viol_vec),
    .locked    (lock_q),
    .flag_clr  (viol_clr),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .rsp_deny  (rsp_deny),
    .flag      (viol_flag)
  );

endmodule

// File: rtl/flash_range_guard_chk.sv
module flash_range_guard_chk
  import flash_guard_pkg::*;
#(
  parameter int NUM_RANGES = 5
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        req_valid,
  input logic                        viol_clr,
  input logic                        rsp_valid,
  input logic                        rsp_grant,
  input logic                        rsp_deny,
  input logic                        viol_flag,
  input logic                        lock_q,
  input range_cfg_t [NUM_RANGES-1:0] cfg_q
);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_grant ^ rsp_deny)); // R7

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_grant | rsp_deny)); // R7

  AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R7

  AST_OPEN_GRANTS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !lock_q) |=> rsp_grant); // R5

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R6

  AST_REGS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(cfg_q)); // R6

  AST_DENY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_deny |-> viol_flag); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_flag && !viol_clr) |=> viol_flag); // R9

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_clr && !req_valid) |=> !viol_flag); // R9

endmodule

bind flash_range_guard flash_range_guard_chk #(.NUM_RANGES(NUM_RANGES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .viol_clr  (viol_clr),
  .rsp_valid (rsp_valid),
  .rsp_grant (rsp_grant),
  .rsp_deny  (rsp_deny),
  .viol_flag (viol_flag),
  .lock_q    (lock_q),
  .cfg_q     (cfg_q)
);

// File: tb/flash_range_guard_test.sv
`timescale 1ns/1ps
module flash_range_guard_test;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic        lock_in;
  logic        req_valid;
  logic [24:0] req_addr;
  logic        req_kind;
  logic        viol_clr;
  logic        rsp_valid, rsp_grant, rsp_deny, viol_flag;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 0;

  // bench model of the register bank (R1, R6)
  logic [31:0] m_reg [5];
  bit          m_locked;

  flash_range_guard uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .lock_in(lock_in), .req_valid(req_valid),
    .req_addr(req_addr), .req_kind(req_kind), .viol_clr(viol_clr),
    .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_deny(rsp_deny),
    .viol_flag(viol_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finish_run();
    end
  end

  // R2 R3 R4 R8: expected denial computed from the field layout
  function automatic bit exp_deny(input logic [24:0] a, input bit kind);
    int page = int'(a[24:12]);
    bit d = 0;
    for (int i = 0; i < 5; i++) begin
      int up = int'(m_reg[i][28:16]);
      int lo = int'(m_reg[i][12:0]);
      bit en = kind ? m_reg[i][31] : m_reg[i][15];
      if (en && page >= lo && page <= up) d = 1;
    end
    return m_locked && d;
  endfunction

  task automatic cfg_write(input int idx, input logic [31:0] data, input bit lk);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx[2:0]; cfg_wdata = data; lock_in = lk;
    @(negedge clk);
    cfg_we = 1'b0; lock_in = 1'b0;
    if (!m_locked && idx < 5) m_reg[idx] = data;
    if (lk) m_locked = 1;
  endtask

  task automatic request(input logic [24:0] a, input bit kind, input bit clr, input string tag);
    bit ed;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_kind = kind; viol_clr = clr;
    ed = exp_deny(a, kind);
    @(posedge clk); #1;
    check({tag, " valid"}, rsp_valid, 1);
    check({tag, " deny"},  rsp_deny, ed);
    check({tag, " grant"}, rsp_grant, !ed);
    @(negedge clk);
    req_valid = 1'b0; viol_clr = 1'b0;
  endtask

  task automatic sweep(input string tag);
    for (int p = 0; p < 41; p++)
      for (int k = 0; k < 2; k++) begin
        request({p[12:0], 12'h000}, k[0], 0, tag);
        request({p[12:0], 12'hFFF}, k[0], 0, tag);
      end
    for (int p = 16'h1FE0; p <= 16'h1FFF; p++)
      for (int k = 0; k < 2; k++)
        request({p[12:0], 12'h7FF}, k[0], 0, tag);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 0; cfg_idx = 0; cfg_wdata = 0; lock_in = 0;
    req_valid = 0; req_addr = 0; req_kind = 0; viol_clr = 0;
    for (int i = 0; i < 5; i++) m_reg[i] = '0;
    m_locked = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R10 rsp_valid", rsp_valid, 0);
    check("R10 grant", rsp_grant, 0);
    check("R10 deny", rsp_deny, 0);
    check("R10 viol_flag", viol_flag, 0);
    @(negedge clk) rst_n = 1'b1;

    // R2: reserved bits set in range 0
    cfg_write(0, 32'hE004_6002, 0);   // wp, pages 2..4
    cfg_write(1, 32'h0008_8008, 0);   // rp, page 8
    cfg_write(2, 32'h8014_8010, 0);   // wp+rp, pages 16..20
    cfg_write(3, 32'h801D_001E, 0);   // wp, lower > upper: empty (R3)
    cfg_write(4, 32'h1FFF_9FF0, 0);   // rp, pages 0x1FF0..0x1FFF
    // R1: out-of-range indices must change nothing
    cfg_write(5, 32'h9FFF_8000, 0);
    cfg_write(6, 32'h9FFF_8000, 0);
    cfg_write(7, 32'h9FFF_8000, 0);

    sweep("R5 open");                  // all granted before lockdown

    // R6: write in the lockdown cycle still lands (overlap with range 0, R8)
    cfg_write(1, 32'h800A_8003, 1);
    cfg_write(3, 32'h9FFF_8000, 0);    // ignored after lockdown (R6)
    cfg_write(0, 32'h0000_0000, 0);    // ignored after lockdown (R6)
    sweep("R3 R4 R8 locked");

    // R9: sticky flag, clear, and clear colliding with a denial
    request(25'h000_2000, 1, 0, "R9 deny");
    @(posedge clk); #1;
    check("R9 flag after deny", viol_flag, 1);
    @(negedge clk) viol_clr = 1'b1;
    @(negedge clk) viol_clr = 1'b0;
    #1 check("R9 flag cleared", viol_flag, 0);
    request(25'h001_0000, 0, 1, "R9 clr+deny");
    #1 check("R9 set wins over clear", viol_flag, 1);
    request(25'h000_0000, 0, 1, "R9 clr+grant");
    #1 check("R9 clear with grant", viol_flag, 0);

    // R7: no request, no response
    @(posedge clk); #1;
    check("R7 idle valid", rsp_valid, 0);
    check("R7 idle grant", rsp_grant, 0);
    check("R7 idle deny", rsp_deny, 0);

    // R6: lockdown survives until reset, then block reopens (R10)
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    m_locked = 0;
    for (int i = 0; i < 5; i++) m_reg[i] = '0;
    request(25'h000_2000, 1, 0, "R10 reopened");
    finish_run();
  end

endmodule